// File: doc/BRIEF.md
# Limit Event Output Register

This block drives a bank of digital output channels from the results of per-scan limit evaluations. An acquisition-start pulse returns every channel to its cleared level. After that, each scan-done strobe updates the channels from a vector of evaluation bits, with one bit per channel.

Each channel has two configuration bits. The invert bit selects whether the cleared level is low or high. The latch bit makes a departure from the cleared level sticky until the next acquisition start. Configuration is written through a simple write port and can be read back at any time. Written settings are staged and reach the channels only when the next acquisition starts, so the behaviour of an acquisition stays consistent while it runs.

Top module: `limit_event_out`

## Requirements
- R1: After reset, every channel output is 0 and both configuration readbacks are 0.
- R2: One cycle after `acq_start_i`, every channel output equals its cleared level, which is the staged invert bit. Any latched departure is released.
- R3: The cleared level of a channel is low when its invert bit is 0 and high when it is 1. A scan drives channel i to `eval_i[i] XOR invert[i]`, so an evaluation bit of 1 means the non-cleared level.
- R4: A channel in tracking mode (latch bit 0) takes its new level one cycle after each `scan_done_i`, following the latest evaluation both away from and back to the cleared level.
- R5: A channel in latched mode (latch bit 1) follows scans while it sits at its cleared level. Once it has left that level, it holds the non-cleared level until the next acquisition start.
- R6: When `acq_start_i` and `scan_done_i` are high in the same cycle, the clear wins and the scan is ignored.
- R7: A configuration write (`cfg_we_i`) appears on the readback outputs one cycle later. The written settings take effect on the channels only at the next `acq_start_i`, and the settings in force for the current acquisition are unchanged until then.
- R8: In a cycle with neither `acq_start_i` nor `scan_done_i`, the channel outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acq_start_i | input | 1 | Acquisition-start pulse; clears every channel |
| scan_done_i | input | 1 | Scan-done strobe; updates the channels |
| eval_i | input | N_CH | Limit evaluation result per channel (1 = limit tripped) |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_inv_i | input | N_CH | Invert bits to write |
| cfg_latch_i | input | N_CH | Latch-mode bits to write |
| cfg_inv_o | output | N_CH | Readback of the staged invert bits |
| cfg_latch_o | output | N_CH | Readback of the staged latch bits |
| chan_o | output | N_CH | Channel output levels |

## Verification
The assertions check the following on every cycle:
- the clear to the staged invert level;
- clear-over-scan priority;
- output stability in idle cycles;
- tracking channels following `eval XOR invert`;
- latched channels holding once they have left the cleared level;
- readback of a write.

The assertions see the settings currently in force through a bound connection. Only the bench scenarios can show the following:
- a mid-acquisition write leaving the current acquisition untouched until the next start;
- a latched channel with a high cleared level tripping and then holding;
- a departure being released by a later start.

// File: rtl/limit_event_pkg.sv
package limit_event_pkg;
  parameter int unsigned LEV_N_CH = 8;

  typedef struct packed {
    logic inv;
    logic latch;
  } lev_mode_t;
endpackage

// File: rtl/lev_cfg.sv
module lev_cfg
  import limit_event_pkg::*;
#(
  parameter int unsigned N_CH = LEV_N_CH
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [N_CH-1:0]       inv_i,
  input  logic [N_CH-1:0]       latch_i,
  input  logic                  load_i,
  output logic [N_CH-1:0]       inv_stg_o,
  output logic [N_CH-1:0]       latch_stg_o,
  output lev_mode_t [N_CH-1:0]  mode_act_o
);
  logic [N_CH-1:0] inv_stg_q, latch_stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_stg_q   <= '0;
      latch_stg_q <= '0;
    end else if (we_i) begin
      inv_stg_q   <= inv_i;
      latch_stg_q <= latch_i;
    end
  end

  // active copy loads the pre-write staged value at acquisition start
  for (genvar g = 0; g < N_CH; g++) begin : g_act
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mode_act_o[g] <= '0;
      end else if (load_i) begin
        mode_act_o[g].inv   <= inv_stg_q[g];
        mode_act_o[g].latch <= latch_stg_q[g];
      end
    end
  end

  assign inv_stg_o   = inv_stg_q;
  assign latch_stg_o = latch_stg_q;
endmodule

// File: rtl/lev_cell.sv
module lev_cell
  import limit_event_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clear_i,
  input  logic      scan_i,
  input  logic      eval_i,
  input  logic      clear_lvl_i,
  input  lev_mode_t mode_i,
  output logic      out_o
);
  logic q;
  logic departed;

  assign departed = (q != mode_i.inv);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= 1'b0;
    end else if (clear_i) begin
      q <= clear_lvl_i;
    end else if (scan_i && !(mode_i.latch && departed)) begin
      q <= eval_i ^ mode_i.inv;
    end
  end

  assign out_o = q;
endmodule

// File: rtl/limit_event_out.sv
module limit_event_out
  import limit_event_pkg::*;
#(
  parameter int unsigned N_CH = LEV_N_CH
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            acq_start_i,
  input  logic            scan_done_i,
  input  logic [N_CH-1:0] eval_i,
  input  logic            cfg_we_i,
  input  logic [N_CH-1:0] cfg_inv_i,
  input  logic [N_CH-1:0] cfg_latch_i,
  output logic [N_CH-1:0] cfg_inv_o,
  output logic [N_CH-1:0] cfg_latch_o,
  output logic [N_CH-1:0] chan_o
);
  lev_mode_t [N_CH-1:0] mode_act;

  lev_cfg #(.N_CH(N_CH)) i_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .inv_i       (cfg_inv_i),
    .latch_i     (cfg_latch_i),
    .load_i      (acq_start_i),
    .inv_stg_o   (cfg_inv_o),
    .latch_stg_o (cfg_latch_o),
    .mode_act_o  (mode_act)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    lev_cell i_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clear_i     (acq_start_i),
      .scan_i      (scan_done_i),
      .eval_i      (eval_i[g]),
      .clear_lvl_i (cfg_inv_o[g]),
      .mode_i      (mode_act[g]),
      .out_o       (chan_o[g])
    );
  end
endmodule

// File: rtl/limit_event_out_chk.sv
module limit_event_out_chk
  import limit_event_pkg::*;
#(
  parameter int unsigned N_CH = LEV_N_CH
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 acq_start_i,
  input logic                 scan_done_i,
  input logic [N_CH-1:0]      eval_i,
  input logic                 cfg_we_i,
  input logic [N_CH-1:0]      cfg_inv_i,
  input logic [N_CH-1:0]      cfg_latch_i,
  input logic [N_CH-1:0]      cfg_inv_o,
  input logic [N_CH-1:0]      cfg_latch_o,
  input logic [N_CH-1:0]      chan_o,
  input lev_mode_t [N_CH-1:0] mode_act
);
  // R2, R6: clear wins, lands on staged invert level
  p_clear_level_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_start_i |=> chan_o == $past(cfg_inv_o));

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acq_start_i && !scan_done_i) |=> $stable(chan_o));

  p_cfg_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (cfg_inv_o == $past(cfg_inv_i)) && (cfg_latch_o == $past(cfg_latch_i)));

  p_cfg_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(cfg_inv_o) && $stable(cfg_latch_o));

  for (genvar g = 0; g < N_CH; g++) begin : g_pc
    p_track_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (scan_done_i && !acq_start_i && !mode_act[g].latch)
      |=> chan_o[g] == ($past(eval_i[g]) ^ $past(mode_act[g].inv)));

    p_latch_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!acq_start_i && mode_act[g].latch && chan_o[g] != mode_act[g].inv)
      |=> $stable(chan_o[g]));
  end
endmodule

bind limit_event_out limit_event_out_chk #(.N_CH(N_CH)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acq_start_i (acq_start_i),
  .scan_done_i (scan_done_i),
  .eval_i      (eval_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_inv_i   (cfg_inv_i),
  .cfg_latch_i (cfg_latch_i),
  .cfg_inv_o   (cfg_inv_o),
  .cfg_latch_o (cfg_latch_o),
  .chan_o      (chan_o),
  .mode_act    (mode_act)
);

// File: tb/test_limit_event_out.sv
module test_limit_event_out;
  localparam int N = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         acq_start_i = 1'b0;
  logic         scan_done_i = 1'b0;
  logic [N-1:0] eval_i = '0;
  logic         cfg_we_i = 1'b0;
  logic [N-1:0] cfg_inv_i = '0;
  logic [N-1:0] cfg_latch_i = '0;
  logic [N-1:0] cfg_inv_o, cfg_latch_o, chan_o;

  always #5 clk_i = ~clk_i;

  limit_event_out #(.N_CH(N)) i_limit_event_out (
    .clk_i, .rst_ni, .acq_start_i, .scan_done_i, .eval_i,
    .cfg_we_i, .cfg_inv_i, .cfg_latch_i,
    .cfg_inv_o, .cfg_latch_o, .chan_o
  );

  typedef struct {
    logic [N-1:0] chan;
    logic [N-1:0] inv;
    logic [N-1:0] lat;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  logic [N-1:0] m_inv_s = '0, m_lat_s = '0, m_inv_a = '0, m_lat_a = '0, m_ch = '0;

  task automatic check(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit acq, bit scan, logic [N-1:0] ev, bit we,
                      logic [N-1:0] inv, logic [N-1:0] lat, string tag);
    exp_t e;
    logic [N-1:0] nxt;
    @(negedge clk_i);
    acq_start_i = acq; scan_done_i = scan; eval_i = ev;
    cfg_we_i = we; cfg_inv_i = inv; cfg_latch_i = lat;
    nxt = m_ch;
    if (acq) nxt = m_inv_s;
    else if (scan)
      for (int i = 0; i < N; i++)
        if (!(m_lat_a[i] && (m_ch[i] != m_inv_a[i]))) nxt[i] = ev[i] ^ m_inv_a[i];
    if (acq) begin m_inv_a = m_inv_s; m_lat_a = m_lat_s; end
    if (we) begin m_inv_s = inv; m_lat_s = lat; end
    m_ch = nxt;
    e.chan = m_ch; e.inv = m_inv_s; e.lat = m_lat_s; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(string tag);
    step(0, 0, 8'h5A, 0, 8'h00, 8'h00, tag);
  endtask

  // monitor: compare one item per cycle after the edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, "chan_o", chan_o, e.chan);
        check(e.tag, "cfg_inv_o", cfg_inv_o, e.inv);
        check(e.tag, "cfg_latch_o", cfg_latch_o, e.lat);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2;
    check("R1", "chan_o", chan_o, '0);
    check("R1", "cfg_inv_o", cfg_inv_o, '0);
    check("R1", "cfg_latch_o", cfg_latch_o, '0);
    @(negedge clk_i) rst_ni = 1'b1;

    step(1, 0, 8'hFF, 0, 0, 0, "R2 R3 default clear low");
    step(0, 1, 8'hA5, 0, 0, 0, "R4 track A5");
    step(0, 1, 8'h3C, 0, 0, 0, "R4 track 3C");
    idle("R8 idle hold");
    step(0, 1, 8'h00, 0, 0, 0, "R4 return to cleared");
    // mid-acquisition write
    step(0, 0, 8'hFF, 1, 8'h0F, 8'hF0, "R7 readback");
    step(0, 1, 8'h81, 0, 0, 0, "R7 old settings still in force");
    step(0, 1, 8'h00, 0, 0, 0, "R7 old settings still in force");
    step(1, 0, 8'h00, 0, 0, 0, "R2 R3 clear to invert level");
    step(0, 1, 8'h00, 0, 0, 0, "R3 eval 0 stays cleared");
    step(0, 1, 8'h81, 0, 0, 0, "R3 R5 trip");
    step(0, 1, 8'h00, 0, 0, 0, "R5 latched hold");
    idle("R8 idle hold latched");
    step(1, 1, 8'hFF, 0, 0, 0, "R6 clear beats scan");
    step(0, 1, 8'h10, 1, 8'hFF, 8'hFF, "R5 R7 latched low-cleared trip");
    step(0, 1, 8'h00, 0, 0, 0, "R5 hold");
    step(1, 0, 8'h00, 0, 0, 0, "R2 R3 clear high");
    step(0, 1, 8'h02, 0, 0, 0, "R5 high-cleared trip");
    step(0, 1, 8'h00, 0, 0, 0, "R5 high-cleared hold");
    step(0, 1, 8'h41, 0, 0, 0, "R5 second trip");
    step(1, 0, 8'h00, 0, 0, 0, "R2 latch released");
    step(0, 1, 8'h00, 0, 0, 0, "R5 follows while cleared");
    idle("R8 final");

    repeat (3) @(posedge clk_i);
    #3;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule